// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block is the core of a memory-mapped NAND flash controller. Software loads a command byte, an address byte, a buffer number and a configuration word through a 16-bit register port. It then writes a one-hot opcode into the trigger register, and the block runs exactly one bus operation on the NAND pins. The available operations are command latch, address latch, page write from RAM, page read into RAM, ID read and status read. Page data lives in an internal byte RAM that holds `NUM_BUFS` buffers. Each buffer is `MAIN_BYTES` main bytes followed by `SPARE_BYTES` spare bytes. The host reaches this RAM through its own byte port.

When an operation ends, the block waits a settle time and then waits for the ready/busy pin to show ready. Only then does it raise a sticky done flag in bit 15 of the trigger register. Software may poll that flag, or it may unmask an interrupt that follows the flag. Strobe widths are parameters counted in core clock cycles. CLE and ALE are set up one cycle before each WE# fall and are held through the whole WE# high time.

Top module: `nand_op_seq`

## Requirements
- R1: After reset the strobes are idle (WE#, RE# and CE# high, CLE and ALE low, no output enable), irq is low, the trigger register reads 0x0000 and the config register reads 0x0010.
- R2: Trigger value 0x0001 produces exactly one WE# pulse with CLE=1, ALE=0 and the low byte of the command register (offset 0x08) on the I/O bus. WE# stays low for WE_LO cycles. CLE, ALE and the data are stable across both WE# edges.
- R3: Trigger value 0x0002 produces exactly one WE# pulse with ALE=1, CLE=0 and the low byte of the address register (offset 0x06) on the I/O bus.
- R4: Trigger value 0x0004 writes the selected buffer to the flash in ascending byte order, with CLE=ALE=0. The buffer number is the value at offset 0x04, and each buffer starts at RAM byte buffer*(MAIN_BYTES+SPARE_BYTES). When config bit 2 (spare-only) is 0, all MAIN_BYTES+SPARE_BYTES bytes are sent. When bit 2 is 1, only the SPARE_BYTES bytes that start at offset MAIN_BYTES are sent.
- R5: Trigger value 0x0008 reads flash bytes with RE# pulses and stores them in ascending order into the selected buffer, over the same range as R4. It produces no WE# pulse, and it leaves RAM outside that range unchanged.
- R6: Trigger value 0x0010 reads ID_LEN bytes into offsets 0 to ID_LEN-1 of the selected buffer. It produces no WE# pulse.
- R7: Trigger value 0x0020 latches the command STATUS_CMD (default 0x70) with CLE and then performs one read. It stores the status byte at buffer offset 0 and 0x00 at offset 1, so the status forms the first 16-bit word.
- R8: Trigger bit 15 is a done flag. A valid start clears it. It is set only after the operation has finished and the ready/busy input is high. Writing 0 to bit 15 clears it, and writing 1 to bit 15 leaves it unchanged.
- R9: irq is high exactly while the done flag is set and config bit 4 (interrupt mask) is 0.
- R10: A trigger write whose bits [5:0] are zero or have more than one bit set starts nothing. A trigger write that arrives while an operation is running also starts nothing, and the running operation continues unchanged.
- R11: CE# is low for the whole of an operation, including the wait on ready/busy. When idle, CE# is high unless config bit 7 (CE force) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ram_we | input | 1 | Host RAM byte write strobe |
| ram_addr | input | clog2(NUM_BUFS*(MAIN_BYTES+SPARE_BYTES)) | Host RAM byte address |
| ram_wdata | input | 8 | Host RAM write data |
| ram_rdata | output | 8 | Host RAM read data (combinational) |
| irq | output | 1 | Completion interrupt |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| ce_n | output | 1 | Chip enable, active low |
| rb_n | input | 1 | Ready (1) / busy (0) from flash |
| io_out | output | 8 | Flash I/O output data |
| io_oe | output | 1 | Flash I/O output enable |
| io_in | input | 8 | Flash I/O input data |

## Verification
The bench builds the block with 32 main bytes, 4 spare bytes, two buffers and a 4-byte ID. With these values, full-page and spare-only transfers, the buffer base arithmetic for the second buffer, and the byte just past the ID are all checked exhaustively in a few hundred cycles. The strobe timings are WE_LO=2, WE_HI=1, RE_LO=2, RE_HI=1 and BUSY_WAIT=2. This puts the minimum one-cycle high phase next to multi-cycle low phases. The ready/busy pin is held low by hand, so the bench can observe the done flag, the ignored re-trigger and CE# during the wait.

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int NUM_BUFS    = 2,
  parameter int ID_LEN      = 5,
  parameter int WE_LO       = 2,
  parameter int WE_HI       = 2,
  parameter int RE_LO       = 2,
  parameter int RE_HI       = 2,
  parameter int BUSY_WAIT   = 4,
  parameter logic [7:0] STATUS_CMD = 8'h70
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        ram_we,
  input  logic [$clog2(NUM_BUFS*(MAIN_BYTES+SPARE_BYTES))-1:0] ram_addr,
  input  logic [7:0]  ram_wdata,
  output logic [7:0]  ram_rdata,
  output logic        irq,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic        ce_n,
  input  logic        rb_n,
  output logic [7:0]  io_out,
  output logic        io_oe,
  input  logic [7:0]  io_in
);
  localparam int BUF_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int RAM_BYTES = NUM_BUFS * BUF_BYTES;
  localparam int RAW = $clog2(RAM_BYTES);
  localparam int BSW = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1;
  localparam int CW  = $clog2(BUF_BYTES + 1);
  localparam int T1  = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int T2  = (RE_LO > RE_HI) ? RE_LO : RE_HI;
  localparam int T3  = (T1 > T2) ? T1 : T2;
  localparam int TMAX = (T3 > BUSY_WAIT) ? T3 : BUSY_WAIT;
  localparam int TW  = $clog2(TMAX) + 1;

  localparam logic [4:0] A_BUFSEL = 5'h04;
  localparam logic [4:0] A_FADDR  = 5'h06;
  localparam logic [4:0] A_FCMD   = 5'h08;
  localparam logic [4:0] A_CFG    = 5'h1A;
  localparam logic [4:0] A_TRIG   = 5'h1C;

  localparam int OP_CMD = 0, OP_ADDR = 1, OP_DIN = 2, OP_DOUT = 3, OP_ID = 4, OP_STAT = 5;
  localparam int CFG_SPARE = 2, CFG_MASK = 4, CFG_CEF = 7;

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WLO, S_WHI, S_RLO, S_RHI, S_SETTLE, S_RBW} st_t;

  logic [7:0]     mem [RAM_BYTES];
  st_t            st;
  logic [5:0]     op_q;
  logic [TW-1:0]  tmr;
  logic [CW-1:0]  cnt, last_q;
  logic [RAW-1:0] base_q;
  logic [7:0]     wbyte_q;
  logic           lcle_q, lale_q, done_q;
  logic [BSW-1:0] bufsel_q;
  logic [15:0]    cmd_q, addr_q, cfg_q;

  logic           trig_wr, start, cap_we, busy, wphase;
  logic [5:0]     opv;
  logic [RAW-1:0] buf_base, first_off, start_addr, cap_addr, nxt_addr;
  logic [CW-1:0]  range_last;

  assign trig_wr   = reg_we && reg_addr == A_TRIG;
  assign opv       = reg_wdata[5:0];
  assign start     = trig_wr && st == S_IDLE && $onehot(opv);
  assign buf_base  = RAW'(bufsel_q) * RAW'(BUF_BYTES);
  assign first_off = cfg_q[CFG_SPARE] ? RAW'(MAIN_BYTES) : '0;
  assign start_addr = buf_base + first_off;
  assign range_last = cfg_q[CFG_SPARE] ? CW'(SPARE_BYTES - 1) : CW'(BUF_BYTES - 1);
  assign cap_addr  = base_q + RAW'(cnt);
  assign nxt_addr  = cap_addr + RAW'(1);
  assign cap_we    = st == S_RLO && tmr == '0;
  assign busy      = st != S_IDLE;
  assign wphase    = st == S_WSET || st == S_WLO || st == S_WHI;

  assign we_n   = st != S_WLO;
  assign re_n   = st != S_RLO;
  assign cle    = lcle_q && wphase;
  assign ale    = lale_q && wphase;
  assign io_oe  = wphase;
  assign io_out = wbyte_q;
  assign ce_n   = !(busy || cfg_q[CFG_CEF]);
  assign irq    = done_q && !cfg_q[CFG_MASK];
  assign ram_rdata = mem[ram_addr];

  always_comb begin
    case (reg_addr)
      A_BUFSEL: reg_rdata = 16'(bufsel_q);
      A_FADDR:  reg_rdata = addr_q;
      A_FCMD:   reg_rdata = cmd_q;
      A_CFG:    reg_rdata = cfg_q;
      A_TRIG:   reg_rdata = {done_q, 9'd0, op_q};
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (cap_we) begin
      mem[cap_addr] <= io_in;
      if (op_q[OP_STAT]) mem[nxt_addr] <= 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bufsel_q <= '0;
      cmd_q    <= '0;
      addr_q   <= '0;
      cfg_q    <= 16'h0010;
    end else if (reg_we) begin
      case (reg_addr)
        A_BUFSEL: bufsel_q <= reg_wdata[BSW-1:0];
        A_FADDR:  addr_q   <= reg_wdata;
        A_FCMD:   cmd_q    <= reg_wdata;
        A_CFG:    cfg_q    <= reg_wdata & 16'h01FC;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= '0;
      tmr     <= '0;
      cnt     <= '0;
      last_q  <= '0;
      base_q  <= '0;
      wbyte_q <= '0;
      lcle_q  <= 1'b0;
      lale_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (start) done_q <= 1'b0;
      else if (st == S_RBW && rb_n) done_q <= 1'b1;
      else if (trig_wr && !reg_wdata[15]) done_q <= 1'b0;

      case (st)
        S_IDLE: if (start) begin
          op_q   <= opv;
          cnt    <= '0;
          lcle_q <= opv[OP_CMD] || opv[OP_STAT];
          lale_q <= opv[OP_ADDR];
          base_q <= opv[OP_DIN] || opv[OP_DOUT] ? start_addr : buf_base;
          if (opv[OP_DIN] || opv[OP_DOUT]) last_q <= range_last;
          else if (opv[OP_ID])             last_q <= CW'(ID_LEN - 1);
          else                             last_q <= '0;
          if (opv[OP_CMD])       wbyte_q <= cmd_q[7:0];
          else if (opv[OP_ADDR]) wbyte_q <= addr_q[7:0];
          else if (opv[OP_STAT]) wbyte_q <= STATUS_CMD;
          else                   wbyte_q <= mem[start_addr];
          if (opv[OP_DOUT] || opv[OP_ID]) begin
            st  <= S_RLO;
            tmr <= TW'(RE_LO - 1);
          end else st <= S_WSET;
        end
        S_WSET: begin
          st  <= S_WLO;
          tmr <= TW'(WE_LO - 1);
        end
        S_WLO: if (tmr == '0) begin
          st  <= S_WHI;
          tmr <= TW'(WE_HI - 1);
        end else tmr <= tmr - 1'b1;
        S_WHI: if (tmr == '0) begin
          if (op_q[OP_STAT]) begin
            st     <= S_RLO;
            tmr    <= TW'(RE_LO - 1);
            lcle_q <= 1'b0;
          end else if (cnt == last_q) begin
            st  <= S_SETTLE;
            tmr <= TW'(BUSY_WAIT - 1);
          end else begin
            st      <= S_WSET;
            cnt     <= cnt + 1'b1;
            wbyte_q <= mem[nxt_addr];
          end
        end else tmr <= tmr - 1'b1;
        S_RLO: if (tmr == '0) begin
          st  <= S_RHI;
          tmr <= TW'(RE_HI - 1);
        end else tmr <= tmr - 1'b1;
        S_RHI: if (tmr == '0) begin
          if (cnt == last_q) begin
            st  <= S_SETTLE;
            tmr <= TW'(BUSY_WAIT - 1);
          end else begin
            st  <= S_RLO;
            cnt <= cnt + 1'b1;
            tmr <= TW'(RE_LO - 1);
          end
        end else tmr <= tmr - 1'b1;
        S_SETTLE: if (tmr == '0) st <= S_RBW;
                  else tmr <= tmr - 1'b1;
        S_RBW: if (rb_n) begin
          st   <= S_IDLE;
          op_q <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_latch_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $stable(cle) && $stable(ale) && $stable(io_out));
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> $stable(cle) && $stable(ale) && $stable(io_out));
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r6_reads_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q[OP_ID] || op_q[OP_DOUT]) |-> we_n);
  a_r8_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(rb_n));
  a_r9_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
  a_r10_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (st == S_IDLE || $stable(op_q)));
  a_r11_ce_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);
endmodule

// File: tb/tb_nand_op_seq.sv
module tb_nand_op_seq;
  localparam int MAIN = 32, SPARE = 4, NB = 2, IDL = 4;
  localparam int BUFB = MAIN + SPARE;
  localparam int RAW = $clog2(NB * BUFB);

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ram_we = 0;
  logic [RAW-1:0] ram_addr = '0;
  logic [7:0] ram_wdata = '0, ram_rdata;
  logic irq, cle, ale, we_n, re_n, ce_n, io_oe;
  logic rb_n = 1;
  logic [7:0] io_out, io_in = '0;

  nand_op_seq #(.MAIN_BYTES(MAIN), .SPARE_BYTES(SPARE), .NUM_BUFS(NB), .ID_LEN(IDL),
    .WE_LO(2), .WE_HI(1), .RE_LO(2), .RE_HI(1), .BUSY_WAIT(2), .STATUS_CMD(8'h70)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .irq(irq), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .ce_n(ce_n), .rb_n(rb_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit mon_en = 0;
  logic [9:0] wlog [0:63];
  logic [7:0] fsrc [0:63];
  logic [7:0] expb [0:63];
  int wcnt = 0, rcnt = 0, rd_idx = 0;

  always @(posedge we_n) if (mon_en) begin
    if (wcnt < 64) wlog[wcnt] = {cle, ale, io_out};
    wcnt++;
  end
  always @(negedge re_n) if (mon_en) begin
    io_in = fsrc[rd_idx % 64];
    rd_idx++;
    rcnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] wentry(input bit c, input bit a, input logic [7:0] d);
    return {c, a, d};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rdr(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic ramw(input int a, input logic [7:0] d);
    @(negedge clk); ram_we = 1; ram_addr = RAW'(a); ram_wdata = d;
    @(negedge clk); ram_we = 0;
  endtask
  task automatic ramr(input int a, output logic [7:0] d);
    @(negedge clk); ram_addr = RAW'(a); #1; d = ram_rdata;
  endtask
  task automatic wait_done(input string req);
    logic [15:0] d;
    bit ok = 0;
    for (int i = 0; i < 3000; i++) begin
      rdr(5'h1C, d);
      if (d[15]) begin ok = 1; break; end
    end
    chk({req, " done flag"}, 32'(ok), 32'd1);
  endtask
  task automatic run_op(input logic [15:0] opc, input string req);
    wcnt = 0; rcnt = 0; rd_idx = 0;
    wr(5'h1C, opc);
    wait_done(req);
  endtask
  task automatic fill_buf(input int b, input logic [7:0] v);
    for (int k = 0; k < BUFB; k++) ramw(b * BUFB + k, v);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0] b8;
    int mis, bsel;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {27'd0, we_n, re_n, ce_n, cle, ale}, {27'd0, 5'b11100});
    chk("R1 irq/oe", {30'd0, irq, io_oe}, 32'd0);
    rdr(5'h1A, d); chk("R1 cfg", 32'(d), 32'h0010);
    rdr(5'h1C, d); chk("R1 trig", 32'(d), 32'h0000);
    mon_en = 1;

    // R2 command latch
    for (int i = 0; i < 4; i++) begin
      b8 = 8'($urandom);
      wr(5'h08, {8'h00, b8});
      run_op(16'h0001, "R2");
      chk("R2 pulses", 32'(wcnt), 32'd1);
      chk("R2 byte", 32'(wlog[0]), 32'(wentry(1, 0, b8)));
    end
    // R3 address latch
    for (int i = 0; i < 4; i++) begin
      b8 = 8'($urandom);
      wr(5'h06, {8'h00, b8});
      run_op(16'h0002, "R3");
      chk("R3 pulses", 32'(wcnt), 32'd1);
      chk("R3 byte", 32'(wlog[0]), 32'(wentry(0, 1, b8)));
    end

    // R4 data input, full page then spare-only
    for (int r = 0; r < 2; r++) begin
      bsel = r;
      wr(5'h04, 16'(bsel));
      for (int k = 0; k < BUFB; k++) begin
        expb[k] = 8'($urandom);
        ramw(bsel * BUFB + k, expb[k]);
      end
      run_op(16'h0004, "R4");
      chk("R4 full count", 32'(wcnt), 32'(BUFB));
      mis = 0;
      for (int k = 0; k < BUFB; k++) if (wlog[k] !== wentry(0, 0, expb[k])) mis++;
      chk("R4 full order", 32'(mis), 32'd0);
      wr(5'h1A, 16'h0014);
      run_op(16'h0004, "R4");
      chk("R4 spare count", 32'(wcnt), 32'(SPARE));
      mis = 0;
      for (int k = 0; k < SPARE; k++) if (wlog[k] !== wentry(0, 0, expb[MAIN + k])) mis++;
      chk("R4 spare order", 32'(mis), 32'd0);
      wr(5'h1A, 16'h0010);
    end

    // R5 data output, full then spare-only
    for (int r = 0; r < 2; r++) begin
      bsel = 1 - r;
      wr(5'h04, 16'(bsel));
      for (int k = 0; k < 64; k++) fsrc[k] = 8'($urandom);
      fill_buf(bsel, 8'hEE);
      run_op(16'h0008, "R5");
      chk("R5 reads", 32'(rcnt), 32'(BUFB));
      chk("R5 no writes", 32'(wcnt), 32'd0);
      mis = 0;
      for (int k = 0; k < BUFB; k++) begin
        ramr(bsel * BUFB + k, b8);
        if (b8 !== fsrc[k]) mis++;
      end
      chk("R5 full data", 32'(mis), 32'd0);
      ramr((1 - bsel) * BUFB, b8);
      fill_buf(bsel, 8'hEE);
      wr(5'h1A, 16'h0014);
      run_op(16'h0008, "R5");
      chk("R5 spare reads", 32'(rcnt), 32'(SPARE));
      mis = 0;
      for (int k = 0; k < SPARE; k++) begin
        ramr(bsel * BUFB + MAIN + k, b8);
        if (b8 !== fsrc[k]) mis++;
      end
      chk("R5 spare data", 32'(mis), 32'd0);
      ramr(bsel * BUFB + MAIN - 1, b8);
      chk("R5 main untouched", 32'(b8), 32'hEE);
      wr(5'h1A, 16'h0010);
    end

    // R6 ID read
    wr(5'h04, 16'd1);
    fill_buf(1, 8'hEE);
    for (int k = 0; k < 64; k++) fsrc[k] = 8'($urandom);
    run_op(16'h0010, "R6");
    chk("R6 no writes", 32'(wcnt), 32'd0);
    mis = 0;
    for (int k = 0; k < IDL; k++) begin
      ramr(BUFB + k, b8);
      if (b8 !== fsrc[k]) mis++;
    end
    chk("R6 id bytes", 32'(mis), 32'd0);
    ramr(BUFB + IDL, b8);
    chk("R6 past id", 32'(b8), 32'hEE);

    // R7 status read
    fill_buf(1, 8'hEE);
    fsrc[0] = 8'hC1;
    run_op(16'h0020, "R7");
    chk("R7 pulses", 32'(wcnt), 32'd1);
    chk("R7 cmd", 32'(wlog[0]), 32'(wentry(1, 0, 8'h70)));
    chk("R7 reads", 32'(rcnt), 32'd1);
    ramr(BUFB, b8);     chk("R7 status byte", 32'(b8), 32'hC1);
    ramr(BUFB + 1, b8); chk("R7 high byte", 32'(b8), 32'h00);
    ramr(BUFB + 2, b8); chk("R7 untouched", 32'(b8), 32'hEE);

    // R8 / R10 flag semantics
    wcnt = 0;
    wr(5'h1C, 16'h8000);
    rdr(5'h1C, d); chk("R8 write one keeps", 32'(d), 32'h8000);
    repeat (20) @(negedge clk);
    chk("R10 zero op", 32'(wcnt), 32'd0);
    wr(5'h1C, 16'h0000);
    rdr(5'h1C, d); chk("R8 write zero clears", 32'(d[15]), 32'd0);
    wr(5'h1C, 16'h0003);
    repeat (30) @(negedge clk);
    chk("R10 multi-bit", 32'(wcnt), 32'd0);
    rdr(5'h1C, d); chk("R10 multi-bit idle", 32'(d[5:0]), 32'd0);

    // R8 busy wait, R10 re-trigger, R11 CE
    rb_n = 0;
    wr(5'h08, 16'h00A5);
    wcnt = 0;
    wr(5'h1C, 16'h0001);
    repeat (40) @(negedge clk);
    rdr(5'h1C, d);
    chk("R8 held by busy", 32'(d), 32'h0001);
    chk("R11 ce during wait", 32'(ce_n), 32'd0);
    wr(5'h1C, 16'h0002);
    rdr(5'h1C, d); chk("R10 busy ignore", 32'(d[5:0]), 32'h01);
    rb_n = 1;
    wait_done("R8");
    chk("R10 single pulse", 32'(wcnt), 32'd1);
    chk("R10 pulse kind", 32'(wlog[0]), 32'(wentry(1, 0, 8'hA5)));
    chk("R11 ce idle", 32'(ce_n), 32'd1);
    wr(5'h1A, 16'h0090);
    chk("R11 ce forced", 32'(ce_n), 32'd0);

    // R9 interrupt
    chk("R9 masked", 32'(irq), 32'd0);
    wr(5'h1A, 16'h0000);
    chk("R9 unmasked", 32'(irq), 32'd1);
    wr(5'h1C, 16'h0000);
    chk("R9 cleared", 32'(irq), 32'd0);
    run_op(16'h0002, "R9");
    chk("R9 after op", 32'(irq), 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule